// File: doc/BRIEF.md
# Auto-Reload Baud Rate Timer

This block is the bit-rate source for an asynchronous serial port. A W-bit up-counter advances once per state-time tick while the run enable is set and at least one of the two clock-source selects (receive or transmit) is set. When the counter steps past all ones it reloads at once from a software-written reload register instead of wrapping to zero. Every second overflow it emits a one-cycle baud pulse. The serial port divides that pulse by 16 to get its sample grid, so the overall bit rate is the tick rate divided by 32 × (2^W − reload).

An overflow in this mode raises no timer flag and requests no interrupt. The external pin goes through a two-stage synchronizer. When its enable is set, a falling edge on the pin sets a sticky flag and does not touch the counter, so the pin can serve as a spare interrupt input. Software may write the counter and the reload register at any time. When an overflow reload and a counter write fall in the same cycle, the reload wins.

Top module: `baud_reload_timer`

## Requirements
- R1: After reset the counter reads 0, the reload register reads 0, the external flag is 0 and the baud pulse is 0.
- R2: When run_en is 1, at least one of rx_clk_sel or tx_clk_sel is 1, and tick is 1, the counter increases by one at the next clock edge (unless R4 or a write applies). With tick at 0 the counter holds.
- R3: With both rx_clk_sel and tx_clk_sel at 0, or run_en at 0, the counter does not advance and no baud pulse appears.
- R4: An advancing tick with the counter at all ones loads the reload value into the counter at that same edge. The counter never passes through zero.
- R5: baud_pulse is high for exactly one cycle on every second overflow. With a tick every k cycles, the spacing between pulses is 2·k·(2^W − reload) cycles.
- R6: When an overflow and a counter write occur in the same cycle, the counter takes the reload value and the written data is dropped.
- R7: A counter write with no overflow in that cycle loads the written data at the next edge. A reload write shows on rld_value at the next edge. An overflow at that same edge still uses the previous reload value.
- R8: With ext_en at 1, a 1-to-0 transition on ext_pin sets ext_flag at the third clock edge after the pin changes, and leaves the counter unchanged.
- R9: A falling edge while ext_en is 0 does not set ext_flag. A rising edge never sets it.
- R10: ext_flag stays set until ext_flag_clr is 1. If a flag-setting edge and the clear occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter run enable |
| tick | input | 1 | State-time tick; one count per tick |
| rx_clk_sel | input | 1 | Use this timer as the receive bit clock |
| tx_clk_sel | input | 1 | Use this timer as the transmit bit clock |
| cnt_wr | input | 1 | Write strobe for the counter |
| cnt_wdata | input | CNT_W | Counter write data |
| rld_wr | input | 1 | Write strobe for the reload register |
| rld_wdata | input | CNT_W | Reload register write data |
| ext_pin | input | 1 | Asynchronous external pin |
| ext_en | input | 1 | Enables flagging of falling edges on ext_pin |
| ext_flag_clr | input | 1 | Clears the external flag |
| baud_pulse | output | 1 | One-cycle pulse every second overflow |
| ext_flag | output | 1 | Sticky external falling-edge flag |
| cnt_value | output | CNT_W | Current counter value |
| rld_value | output | CNT_W | Current reload register value |

## Verification
The bench uses the default parameters: CNT_W = 16, DIV_LOG2 = 1 and SYNC_DEPTH = 2. Reload values close to all ones keep the overflow period to a few cycles, so the full 16-bit boundary (FFFF to reload) is reached often. A vector table measures pulse spacing across several reload values and tick densities. Directed sequences cover same-cycle collisions (reload against counter write, reload against reload-register write, flag set against clear) and the three-edge synchronizer latency of the pin.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_STEP   = 2'd1,
        CNT_WRITE  = 2'd2,
        CNT_RELOAD = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic rx_sel;
        logic tx_sel;
    } clk_sel_t;

    function automatic logic baud_mode_on(input clk_sel_t sel);
        return sel.rx_sel | sel.tx_sel;
    endfunction

    // reload beats a software write; a write beats a plain step
    function automatic cnt_op_e pick_cnt_op(input logic wrap, input logic wr,
                                            input logic step);
        if (wrap)      return CNT_RELOAD;
        else if (wr)   return CNT_WRITE;
        else if (step) return CNT_STEP;
        else           return CNT_HOLD;
    endfunction

endpackage

// File: rtl/brt_counter.sv
module brt_counter
    import brt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    output logic         wrap,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] rld_q
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    cnt_op_e op;

    assign wrap = advance && (cnt_q == ALL_ONES);
    assign op   = pick_cnt_op(wrap, cnt_wr, advance);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_RELOAD: cnt_q <= rld_q;
                CNT_WRITE:  cnt_q <= cnt_wdata;
                CNT_STEP:   cnt_q <= cnt_q + 1'b1;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rld_q <= '0;
        else if (rld_wr) rld_q <= rld_wdata;
    end

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_q == ALL_ONES) |=> (cnt_q == $past(rld_q))); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (advance && !cnt_wr && cnt_q != ALL_ONES) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_RELOAD_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (advance && cnt_wr && cnt_q == ALL_ONES) |=> (cnt_q == $past(rld_q))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!advance && !cnt_wr) |=> $stable(cnt_q)); // R3

    AST_RLD_WRITE: assert property (@(posedge clk) disable iff (rst)
        rld_wr |=> (rld_q == $past(rld_wdata))); // R7

endmodule

// File: rtl/brt_baud_div.sv
module brt_baud_div #(
    parameter int unsigned DIV_LOG2 = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic baud_pulse
);
    generate
        if (DIV_LOG2 == 0) begin : g_nodiv
            always_ff @(posedge clk) begin
                if (rst) baud_pulse <= 1'b0;
                else     baud_pulse <= wrap;
            end
        end else begin : g_div
            logic [DIV_LOG2-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase      <= '0;
                    baud_pulse <= 1'b0;
                end else begin
                    baud_pulse <= wrap && (phase == {DIV_LOG2{1'b1}});
                    if (wrap) phase <= phase + 1'b1;
                end
            end

            AST_BAUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                baud_pulse |=> !baud_pulse); // R5

            AST_BAUD_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
                baud_pulse |-> $past(wrap)); // R5
        end
    endgenerate

endmodule

// File: rtl/brt_ext_edge.sv
module brt_ext_edge #(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic en,
    input  logic clr,
    output logic flag
);
    logic [SYNC_DEPTH-1:0] chain;
    logic                  prev;
    logic                  synced;
    logic                  fall;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[SYNC_DEPTH-2:0], pin};
    end

    assign synced = chain[SYNC_DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= synced;
    end

    assign fall = prev && !synced;

    always_ff @(posedge clk) begin
        if (rst)               flag <= 1'b0;
        else if (fall && en)   flag <= 1'b1;
        else if (clr)          flag <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R10

    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!flag && !en) |=> !flag); // R9

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (fall && en) |=> flag); // R10

endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
    import brt_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DIV_LOG2   = 1,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             tick,
    input  logic             rx_clk_sel,
    input  logic             tx_clk_sel,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             ext_pin,
    input  logic             ext_en,
    input  logic             ext_flag_clr,
    output logic             baud_pulse,
    output logic             ext_flag,
    output logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] rld_value
);
    clk_sel_t sel;
    logic     mode_on;
    logic     advance;
    logic     wrap;

    assign sel     = '{rx_sel: rx_clk_sel, tx_sel: tx_clk_sel};
    assign mode_on = baud_mode_on(sel);
    assign advance = run_en && mode_on && tick;

    brt_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rld_wr    (rld_wr),
        .rld_wdata (rld_wdata),
        .wrap      (wrap),
        .cnt_q     (cnt_value),
        .rld_q     (rld_value)
    );

    brt_baud_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .baud_pulse (baud_pulse)
    );

    brt_ext_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_ext (
        .clk  (clk),
        .rst  (rst),
        .pin  (ext_pin),
        .en   (ext_en),
        .clr  (ext_flag_clr),
        .flag (ext_flag)
    );

    AST_BAUD_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(baud_pulse) |-> $past(run_en && (rx_clk_sel || tx_clk_sel))); // R3

endmodule

// File: tb/baud_reload_timer_test.sv
module baud_reload_timer_test;
    localparam int W = 16;

    // {reload, tick spacing, expected pulse spacing in cycles}
    localparam int NVEC = 5;
    localparam logic [47:0] VEC [NVEC] = '{
        {16'hFFFF, 16'd1, 16'd2},
        {16'hFFFE, 16'd1, 16'd4},
        {16'hFFFC, 16'd2, 16'd16},
        {16'hFFF0, 16'd1, 16'd32},
        {16'hFF00, 16'd3, 16'd1536}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         tick;
    logic         tick_man = 1'b0;
    logic         tick_gen = 1'b0;
    logic         tick_auto = 1'b0;
    int           tick_every = 1;
    logic         rx_clk_sel = 1'b0;
    logic         tx_clk_sel = 1'b0;
    logic         cnt_wr = 1'b0;
    logic [W-1:0] cnt_wdata = '0;
    logic         rld_wr = 1'b0;
    logic [W-1:0] rld_wdata = '0;
    logic         ext_pin = 1'b1;
    logic         ext_en = 1'b0;
    logic         ext_flag_clr = 1'b0;
    logic         baud_pulse;
    logic         ext_flag;
    logic [W-1:0] cnt_value;
    logic [W-1:0] rld_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign tick = tick_auto ? tick_gen : tick_man;

    always #5 clk = ~clk;

    baud_reload_timer uut (
        .clk(clk), .rst(rst), .run_en(run_en), .tick(tick),
        .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .ext_pin(ext_pin), .ext_en(ext_en), .ext_flag_clr(ext_flag_clr),
        .baud_pulse(baud_pulse), .ext_flag(ext_flag),
        .cnt_value(cnt_value), .rld_value(rld_value)
    );

    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            tick_gen = (phase == 0);
            phase = (phase + 1 >= tick_every) ? 0 : phase + 1;
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 cnt", cnt_value, 0);
        chk("R1 rld", rld_value, 0);
        chk("R1 flag", ext_flag, 0);
        chk("R1 baud", baud_pulse, 0);

        // table walk: pulse spacing, R5
        for (int i = 0; i < NVEC; i++) begin
            int n;
            int guard;
            tick_auto = 1'b0; run_en = 1'b0;
            rld_wr = 1'b1; rld_wdata = VEC[i][47:32];
            cnt_wr = 1'b1; cnt_wdata = VEC[i][47:32];
            cyc();
            rld_wr = 1'b0; cnt_wr = 1'b0;
            tick_every = int'(VEC[i][31:16]);
            tick_auto = 1'b1; run_en = 1'b1; tx_clk_sel = 1'b1;
            guard = 0;
            while (!baud_pulse && guard < 5000) begin cyc(); guard++; end
            n = 0;
            cyc(); n++;
            chk("R5 width", baud_pulse && VEC[i][15:0] != 16'd2, 0);
            while (!baud_pulse && n < 5000) begin cyc(); n++; end
            chk("R5 period", n, VEC[i][15:0]);
        end
        tick_auto = 1'b0; tick_every = 1; run_en = 1'b0; tx_clk_sel = 1'b0;
        cyc();

        // R2 stepping
        cnt_wr = 1'b1; cnt_wdata = 16'h1234; cyc(); cnt_wr = 1'b0;
        chk("R7 write", cnt_value, 16'h1234);
        run_en = 1'b1; tx_clk_sel = 1'b1; tick_man = 1'b1;
        cyc(); cyc(); cyc();
        chk("R2 step", cnt_value, 16'h1237);
        tick_man = 1'b0; cyc();
        chk("R2 no tick hold", cnt_value, 16'h1237);
        tx_clk_sel = 1'b0; rx_clk_sel = 1'b1; tick_man = 1'b1; cyc();
        chk("R2 rx select", cnt_value, 16'h1238);

        // R3 mode off
        rx_clk_sel = 1'b0;
        for (int k = 0; k < 5; k++) begin
            cyc();
            chk("R3 baud off", baud_pulse, 0);
        end
        chk("R3 cnt held", cnt_value, 16'h1238);
        tx_clk_sel = 1'b1; run_en = 1'b0; cyc(); cyc();
        chk("R3 run off", cnt_value, 16'h1238);

        // R4 reload on wrap
        tick_man = 1'b0;
        rld_wr = 1'b1; rld_wdata = 16'hABCD;
        cnt_wr = 1'b1; cnt_wdata = 16'hFFFE; cyc();
        rld_wr = 1'b0; cnt_wr = 1'b0;
        chk("R7 rld write", rld_value, 16'hABCD);
        run_en = 1'b1; tick_man = 1'b1;
        cyc(); chk("R4 at ones", cnt_value, 16'hFFFF);
        cyc(); chk("R4 reload", cnt_value, 16'hABCD);
        cyc(); chk("R4 after", cnt_value, 16'hABCE);

        // R6 reload beats write
        tick_man = 1'b0; cnt_wr = 1'b1; cnt_wdata = 16'hFFFF; cyc();
        tick_man = 1'b1; cnt_wdata = 16'h5555; cyc();
        chk("R6 priority", cnt_value, 16'hABCD);
        tick_man = 1'b0; cyc();
        chk("R7 write no wrap", cnt_value, 16'h5555);

        // R7 reload write at wrap uses old value
        cnt_wdata = 16'hFFFF; cyc(); cnt_wr = 1'b0;
        tick_man = 1'b1; rld_wr = 1'b1; rld_wdata = 16'h1111; cyc();
        rld_wr = 1'b0; tick_man = 1'b0;
        chk("R7 old reload", cnt_value, 16'hABCD);
        chk("R7 new rld", rld_value, 16'h1111);
        run_en = 1'b0;

        // R8 falling edge latency
        ext_en = 1'b1; ext_pin = 1'b1;
        repeat (4) cyc();
        ext_pin = 1'b0;
        cyc(); chk("R8 edge1", ext_flag, 0);
        cyc(); chk("R8 edge2", ext_flag, 0);
        cyc(); chk("R8 edge3", ext_flag, 1);
        chk("R8 cnt untouched", cnt_value, 16'hABCD);

        // R10 clear and hold
        ext_flag_clr = 1'b1; cyc(); ext_flag_clr = 1'b0;
        chk("R10 clear", ext_flag, 0);
        ext_pin = 1'b1;
        repeat (4) cyc();
        chk("R9 rising ignored", ext_flag, 0);
        ext_pin = 1'b0;
        repeat (3) cyc();
        chk("R8 second edge", ext_flag, 1);
        repeat (5) cyc();
        chk("R10 sticky", ext_flag, 1);

        // R10 set beats clear
        ext_flag_clr = 1'b1; cyc();
        chk("R10 clear2", ext_flag, 0);
        ext_flag_clr = 1'b0; ext_pin = 1'b1;
        repeat (4) cyc();
        ext_pin = 1'b0;
        cyc(); cyc();
        ext_flag_clr = 1'b1; cyc();
        chk("R10 set wins", ext_flag, 1);
        cyc();
        chk("R10 clear after", ext_flag, 0);
        ext_flag_clr = 1'b0;

        // R9 disabled edge
        ext_en = 1'b0; ext_pin = 1'b1;
        repeat (4) cyc();
        ext_pin = 1'b0;
        repeat (5) cyc();
        chk("R9 disabled", ext_flag, 0);
        chk("R8 cnt still", cnt_value, 16'hABCD);

        finish_run();
    end

endmodule